// File: doc/BRIEF.md
# Configuration Register Loader with Gray-Level Palette

This block holds a bank of 32 four-bit configuration registers for a display path. Sixteen of them form a palette: each one gives the 3-bit gray level (0 to 7) for one 4-bit IRGB colour code. A combinational lookup port turns an incoming colour code into its gray level in the same cycle. The whole bank is visible as one flat vector, so the logic around the block can decode the remaining registers.

The registers can be loaded in two ways, and a mode pin picks one while reset is held. In host mode a processor writes one register at a time with a chip select, a write strobe, a 5-bit address and 4-bit data. In ROM mode the block loads itself. It drives the 5-bit address to an external ROM and holds each address for a fixed read cycle of 16 clocks. It samples the returned nibble on the last clock of that cycle, then moves to the next address, and wraps back to zero after address 31. A flag rises once the first full pass has been stored.

Top module: `cfgreg_loader`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears to 0, `load_done_o` goes low and the ROM address counter returns to 0.
- R2: In host mode, at each clock edge where `host_cs_i` and `host_wr_i` are both 1, register `host_addr_i` takes `host_data_i`. When either of them is 0, no register changes.
- R3: The load mode comes from `rom_mode_i` (1 = ROM, 0 = host) and is taken only at edges where `rst` is high. A change on the pin outside reset has no effect. `addr_oe_o` is 1 exactly in ROM mode.
- R4: In ROM mode `rom_addr_o` starts at 0 after reset and holds each value for 16 clocks. It then steps by one and wraps from 31 to 0. In host mode it stays 0.
- R5: In ROM mode, at the 16th clock edge of each read cycle, the register at the current `rom_addr_o` takes the value on `rom_data_i`. The first write happens at the 16th edge after reset is released.
- R6: In ROM mode `load_done_o` rises at the edge that stores address 31 of the first pass, which is edge 512 after reset is released. It then stays high until reset. In host mode it stays 0.
- R7: `gray_o` always equals bits [2:0] of register `color_i`, where `color_i` ranges over 0 to 15, with no clock delay. Bit 3 of those registers has no effect on `gray_o`.
- R8: In ROM mode host write strobes are ignored.
- R9: `cfg_o` carries register n in bits [4n+3:4n] for n = 0 to 31. Registers 16 to 31 keep all four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_mode_i | input | 1 | Load mode select, taken during reset (1 = ROM) |
| host_cs_i | input | 1 | Host chip select |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 5 | Host register address |
| host_data_i | input | 4 | Host write data |
| rom_addr_o | output | 5 | Address driven to the external ROM |
| addr_oe_o | output | 1 | Address bus drive enable (1 in ROM mode) |
| rom_data_i | input | 4 | Nibble returned by the external ROM |
| load_done_o | output | 1 | First ROM pass complete |
| color_i | input | 4 | IRGB colour code to look up |
| gray_o | output | 3 | Gray level for `color_i` |
| cfg_o | output | 128 | All 32 registers, register n at bits [4n+3:4n] |

## Verification
Two clashes matter here. The first is a host write strobe that lands on the same edge as the sequencer's sample in ROM mode; the host must lose. The second is a palette lookup of an entry on the cycle that entry is being rewritten; the old level must show until the edge. The bench holds chip select and strobe active with a colliding address through whole ROM passes, and sweeps `color_i` every clock so the lookup meets every entry as it is loaded. A behavioural model in the bench predicts all outputs each clock, and every output is compared on every falling edge.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    parameter int ADDR_W     = 5;
    parameter int DATA_W     = 4;
    parameter int GRAY_W     = 3;
    parameter int COLOR_W    = 4;
    parameter int ROM_CYCLE  = 16;

    localparam int NUM_REGS    = 1 << ADDR_W;
    localparam int PAL_ENTRIES = 1 << COLOR_W;
    localparam int FLAT_W      = NUM_REGS * DATA_W;

    typedef enum logic {
        LOAD_HOST = 1'b0,
        LOAD_ROM  = 1'b1
    } load_mode_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(NUM_REGS - 1)) ? '0 : a + 1'b1;
    endfunction

endpackage

// File: rtl/cfgreg_rom_seq.sv
module cfgreg_rom_seq
    import cfgreg_pkg::*;
#(
    parameter int CYCLE = ROM_CYCLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output wr_req_t           wr_o,
    output logic              done_o
);
    localparam int TICK_W = (CYCLE > 1) ? $clog2(CYCLE) : 1;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(CYCLE - 1);

    logic [TICK_W-1:0] tick_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              sample;

    assign sample = enable && (tick_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else if (enable) begin
            if (sample) begin
                tick_q <= '0;
                addr_q <= step_addr(addr_q);
                if (addr_q == ADDR_W'(NUM_REGS - 1)) begin
                    done_q <= 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign addr_o  = addr_q;
    assign done_o  = done_q;
    assign wr_o.en   = sample;
    assign wr_o.addr = addr_q;
    assign wr_o.data = rom_data_i;

endmodule

// File: rtl/cfgreg_file.sv
module cfgreg_file
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_i,
    output logic [FLAT_W-1:0] flat_o
);
    for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (wr_i.en && (wr_i.addr == ADDR_W'(n))) begin
                val_q <= wr_i.data;
            end
        end
        assign flat_o[n*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/cfgreg_palette.sv
module cfgreg_palette
    import cfgreg_pkg::*;
(
    input  logic [FLAT_W-1:0]  flat_i,
    input  logic [COLOR_W-1:0] color_i,
    output logic [GRAY_W-1:0]  gray_o
);
    logic [GRAY_W-1:0] level [PAL_ENTRIES];

    for (genvar e = 0; e < PAL_ENTRIES; e++) begin : g_entry
        assign level[e] = flat_i[e*DATA_W +: GRAY_W];
    end

    assign gray_o = level[color_i];

endmodule

// File: rtl/cfgreg_loader.sv
module cfgreg_loader
    import cfgreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rom_mode_i,
    input  logic               host_cs_i,
    input  logic               host_wr_i,
    input  logic [ADDR_W-1:0]  host_addr_i,
    input  logic [DATA_W-1:0]  host_data_i,
    output logic [ADDR_W-1:0]  rom_addr_o,
    output logic               addr_oe_o,
    input  logic [DATA_W-1:0]  rom_data_i,
    output logic               load_done_o,
    input  logic [COLOR_W-1:0] color_i,
    output logic [GRAY_W-1:0]  gray_o,
    output logic [FLAT_W-1:0]  cfg_o
);
    load_mode_e        mode_q;
    logic              rom_en;
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_done;
    wr_req_t           seq_wr;
    wr_req_t           host_wr;
    wr_req_t           wr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= load_mode_e'(rom_mode_i);
        end
    end

    assign rom_en = (mode_q == LOAD_ROM);

    assign host_wr.en   = host_cs_i && host_wr_i;
    assign host_wr.addr = host_addr_i;
    assign host_wr.data = host_data_i;

    cfgreg_rom_seq #(.CYCLE(ROM_CYCLE)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (rom_en),
        .rom_data_i (rom_data_i),
        .addr_o     (seq_addr),
        .wr_o       (seq_wr),
        .done_o     (seq_done)
    );

    always_comb begin
        if (rom_en) begin
            wr_sel = seq_wr;
        end else begin
            wr_sel = host_wr;
        end
    end

    cfgreg_file u_file (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_sel),
        .flat_o (cfg_o)
    );

    cfgreg_palette u_pal (
        .flat_i  (cfg_o),
        .color_i (color_i),
        .gray_o  (gray_o)
    );

    assign rom_addr_o  = rom_en ? seq_addr : '0;
    assign addr_oe_o   = rom_en;
    assign load_done_o = rom_en && seq_done;

endmodule

// File: rtl/cfgreg_loader_chk.sv
module cfgreg_loader_chk
    import cfgreg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_cs_i,
    input logic               host_wr_i,
    input logic [ADDR_W-1:0]  host_addr_i,
    input logic [DATA_W-1:0]  host_data_i,
    input logic [ADDR_W-1:0]  rom_addr_o,
    input logic               addr_oe_o,
    input logic               load_done_o,
    input logic [COLOR_W-1:0] color_i,
    input logic [GRAY_W-1:0]  gray_o,
    input logic [FLAT_W-1:0]  cfg_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (cfg_o == '0 && !load_done_o)); // R1

    AST_HOST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!addr_oe_o && !$past(rst) && $past(host_cs_i && host_wr_i))
        |-> (cfg_o[int'($past(host_addr_i))*DATA_W +: DATA_W] == $past(host_data_i))); // R2

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(addr_oe_o)); // R3

    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (addr_oe_o && !$past(rst) && (rom_addr_o != $past(rom_addr_o)))
        |-> (rom_addr_o == step_addr($past(rom_addr_o)))); // R4

    AST_HOST_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !addr_oe_o |-> (rom_addr_o == '0)); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        load_done_o |=> load_done_o); // R6

    AST_DONE_ROM_ONLY: assert property (@(posedge clk) disable iff (rst)
        load_done_o |-> addr_oe_o); // R6

    AST_GRAY_FROM_REG: assert property (@(posedge clk) disable iff (rst)
        gray_o == cfg_o[int'(color_i)*DATA_W +: GRAY_W]); // R7

endmodule

bind cfgreg_loader cfgreg_loader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_cs_i   (host_cs_i),
    .host_wr_i   (host_wr_i),
    .host_addr_i (host_addr_i),
    .host_data_i (host_data_i),
    .rom_addr_o  (rom_addr_o),
    .addr_oe_o   (addr_oe_o),
    .load_done_o (load_done_o),
    .color_i     (color_i),
    .gray_o      (gray_o),
    .cfg_o       (cfg_o)
);

// File: tb/cfgreg_loader_bench.sv
module cfgreg_loader_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rom_mode = 1'b0;
    logic         cs = 1'b0;
    logic         wr = 1'b0;
    logic [4:0]   haddr = '0;
    logic [3:0]   hdata = '0;
    logic [4:0]   rom_addr;
    logic         addr_oe;
    logic [3:0]   rom_data;
    logic         done;
    logic [3:0]   color = '0;
    logic [2:0]   gray;
    logic [127:0] cfg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit color_auto = 1'b1;
    string cur_req = "R2";

    logic [3:0] rom_img [32];

    // behavioural reference state
    logic [3:0] m_reg [32];
    bit         m_mode = 1'b0;
    int         m_tick = 0;
    int         m_addr = 0;
    bit         m_done = 1'b0;

    always #10 clk = ~clk;

    assign rom_data = rom_img[rom_addr];

    cfgreg_loader u_cfgreg_loader (
        .clk         (clk),
        .rst         (rst),
        .rom_mode_i  (rom_mode),
        .host_cs_i   (cs),
        .host_wr_i   (wr),
        .host_addr_i (haddr),
        .host_data_i (hdata),
        .rom_addr_o  (rom_addr),
        .addr_oe_o   (addr_oe),
        .rom_data_i  (rom_data),
        .load_done_o (done),
        .color_i     (color),
        .gray_o      (gray),
        .cfg_o       (cfg)
    );

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int n = 0; n < 32; n++) f[n*4 +: 4] = m_reg[n];
        return f;
    endfunction

    // reference model, advanced at every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_mode = rom_mode;
            for (int n = 0; n < 32; n++) m_reg[n] = 4'h0;
            m_tick = 0;
            m_addr = 0;
            m_done = 1'b0;
        end else if (m_mode) begin
            if (m_tick == 15) begin
                m_reg[m_addr] = rom_img[m_addr];
                if (m_addr == 31) m_done = 1'b1;
                m_addr = (m_addr + 1) % 32;
                m_tick = 0;
            end else begin
                m_tick++;
            end
        end else if (cs && wr) begin
            m_reg[haddr] = hdata;
        end
        if (color_auto) begin
            #2 color <= color + 4'd1;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(cur_req, "cfg_o", cfg, model_flat());
            check("R4", "rom_addr_o", {123'd0, rom_addr}, m_mode ? 128'(m_addr) : 128'd0);
            check("R3", "addr_oe_o", {127'd0, addr_oe}, {127'd0, m_mode});
            check("R6", "load_done_o", {127'd0, done}, {127'd0, m_done});
            check("R7", "gray_o", {125'd0, gray}, {125'd0, m_reg[color][2:0]});
        end
    end

    task automatic do_reset(input logic mode);
        @(posedge clk); #2;
        rst = 1'b1;
        rom_mode = mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cfg_o in reset", cfg, 128'd0);
        check("R1", "done in reset", {127'd0, done}, 128'd0);
        check("R1", "rom addr in reset", {123'd0, rom_addr}, 128'd0);
        @(posedge clk); #2;
        rst = 1'b0;
    endtask

    task automatic host_write(input logic [4:0] a, input logic [3:0] d, input logic c, input logic w);
        @(posedge clk); #2;
        cs = c; wr = w; haddr = a; hdata = d;
        @(posedge clk); #2;
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic look(input logic [3:0] c, input logic [2:0] exp, input string what);
        color_auto = 1'b0;
        @(posedge clk); #4;
        color = c;
        #1;
        check("R7", what, {125'd0, gray}, {125'd0, exp});
        @(negedge clk);
        color_auto = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rom_img[i] = 4'((i * 5 + 3) & 15);

        // host mode
        do_reset(1'b0);
        cur_req = "R2";
        for (int i = 0; i < 16; i++) host_write(5'(i), 4'(15 - i), 1'b1, 1'b1);
        @(negedge clk);
        check("R2", "reg 5 after host write", {124'd0, cfg[23:20]}, 128'd10);
        host_write(5'd5, 4'h3, 1'b0, 1'b1);
        host_write(5'd5, 4'h3, 1'b1, 1'b0);
        @(negedge clk);
        check("R2", "reg 5 unchanged without cs or strobe", {124'd0, cfg[23:20]}, 128'd10);
        cur_req = "R9";
        host_write(5'd20, 4'hB, 1'b1, 1'b1);
        host_write(5'd31, 4'hE, 1'b1, 1'b1);
        @(negedge clk);
        check("R9", "reg 20 full nibble", {124'd0, cfg[83:80]}, 128'd11);
        check("R9", "reg 31 full nibble", {124'd0, cfg[127:124]}, 128'd14);
        host_write(5'd3, 4'hD, 1'b1, 1'b1);
        look(4'd3, 3'd5, "entry 3 ignores bit 3");
        look(4'd0, 3'd7, "entry 0 level");
        cur_req = "R3";
        @(posedge clk); #2;
        rom_mode = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R3", "pin change outside reset ignored", {127'd0, addr_oe}, 128'd0);
        check("R6", "done stays low in host mode", {127'd0, done}, 128'd0);

        // ROM mode, first pass with a colliding host strobe held active
        do_reset(1'b1);
        cur_req = "R5";
        cs = 1'b1; wr = 1'b1; haddr = 5'd0; hdata = 4'hF;
        repeat (15) @(posedge clk);
        @(negedge clk);
        check("R5", "no write before edge 16", {124'd0, cfg[3:0]}, 128'd0);
        @(posedge clk);
        @(negedge clk);
        check("R5", "reg 0 loaded at edge 16", {124'd0, cfg[3:0]}, 128'(rom_img[0]));
        check("R4", "address steps after 16 clocks", {123'd0, rom_addr}, 128'd1);
        check("R8", "host strobe lost to sequencer", {124'd0, cfg[3:0]}, 128'(rom_img[0]));
        repeat (495) @(posedge clk);
        @(negedge clk);
        check("R6", "done low before edge 512", {127'd0, done}, 128'd0);
        @(posedge clk);
        @(negedge clk);
        check("R6", "done high at edge 512", {127'd0, done}, 128'd1);
        check("R4", "address wrapped to 0", {123'd0, rom_addr}, 128'd0);
        check("R8", "reg 31 from rom", {124'd0, cfg[127:124]}, 128'(rom_img[31]));

        // second pass with new ROM contents
        cur_req = "R4";
        for (int i = 0; i < 32; i++) rom_img[i] = 4'(i ^ 15);
        haddr = 5'd9;
        repeat (512) @(posedge clk);
        @(negedge clk);
        check("R4", "second pass reloads reg 9", {124'd0, cfg[39:36]}, 128'd6);
        check("R6", "done stays high", {127'd0, done}, 128'd1);
        cs = 1'b0; wr = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule